// File: doc/BRIEF.md
# Serial ADC Frame Reader with Power Policy

This block is a host-side controller for a 10-bit serial analog-to-digital converter. The link has three wires: an active-low select, a serial clock and a data line from the converter. A pulse on the sample request starts a full 16-clock frame. The 10-bit straight-binary result then comes back with a one-cycle valid strobe. A pulse on the power-down request starts a short frame instead. That frame releases select after a programmable number of serial clock falling edges, between 1 and 9. The converter treats a select release before its tenth falling edge as a command to enter low-power mode.

The serial clock comes from the system clock. Each half period of the serial clock lasts `div_half + 1` system clocks. The divider setting and the short-frame edge count are captured when a request is accepted. The controller ignores any request that arrives while a frame or the gap after it is in progress, and it drives `busy` high for that whole time.

Top module: `adc_frame_reader`

## Requirements
- R1: During and directly after reset, `adc_cs_n` and `adc_sclk` are 1, while `busy`, `smp_valid` and `smp_data` are 0.
- R2: A sample frame drives exactly 16 falling edges of `adc_sclk` while `adc_cs_n` is low. `adc_cs_n` rises together with the rising `adc_sclk` edge that follows the 16th falling edge.
- R3: `adc_sdata` is sampled on each rising edge of `adc_sclk`. The result is made of the bits taken at rising edges 4 to 13, most significant bit first, so it is bits 12..3 of the 16-bit word that was shifted in. The result appears on `smp_data` with a single-cycle `smp_valid` pulse in the cycle where `adc_cs_n` rises. `smp_data` holds that value until the next sample frame ends.
- R4: A power-down frame drives N falling edges and then releases `adc_cs_n`, and it gives no `smp_valid` pulse. N is `sd_edges` clamped to the range 1..9, so a setting of 0 gives 1 and a setting above 9 gives 9.
- R5: Each half period of `adc_sclk` lasts `div_half + 1` system clocks. `smp_valid` rises 32·(`div_half`+1) clocks after the clock edge that accepts a sample request.
- R6: `adc_sclk` is high whenever `adc_cs_n` is high.
- R7: After a frame, `adc_cs_n` stays high for 2·(`div_half`+1) clocks while `busy` stays high. `busy` falls 2·(N+1)·(`div_half`+1) clocks after the accepting edge, where N is 16 for a sample frame.
- R8: While `busy` is high, `smp_req` and `pdn_req` have no effect.
- R9: If both requests are high in the same accepting cycle, a sample frame is run.
- R10: `div_half` and `sd_edges` are captured at acceptance, so changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_req | input | 1 | Start a full conversion frame |
| pdn_req | input | 1 | Start a short frame that powers the converter down |
| div_half | input | DIV_W | Serial clock half period minus one, in system clocks |
| sd_edges | input | 4 | Falling-edge count for a power-down frame |
| busy | output | 1 | Frame or inter-frame gap in progress |
| smp_valid | output | 1 | One-cycle strobe for a new result |
| smp_data | output | RES_W | Last conversion result, straight binary |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdata | input | 1 | Serial data from the converter |

## Verification
The request is driven on the falling system clock edge, and the bench counts falling edges from there. The edge that accepts the request is edge zero. `smp_valid` is therefore first seen at count 32·(d+1)+1 and `busy` is first seen low at count 2·(N+1)·(d+1)+1, where d is the divider. The bench checks both counts exactly, for each vector and each directed case. A model of the converter in the bench drives one bit per falling serial clock edge and counts those edges. The bench compares the edge count, the number of valid pulses and the returned code once `busy` has dropped.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV_W     = 8,
  parameter int RES_W     = 10,
  parameter int FRAME_LEN = 16,
  parameter int LEAD_BITS = 3,
  parameter int SD_MAX    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_req,
  input  logic             pdn_req,
  input  logic [DIV_W-1:0] div_half,
  input  logic [3:0]       sd_edges,
  output logic             busy,
  output logic             smp_valid,
  output logic [RES_W-1:0] smp_data,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  input  logic             adc_sdata
);
  localparam int CNT_W   = $clog2(FRAME_LEN + 1);
  localparam int MSB_POS = FRAME_LEN - 1 - LEAD_BITS;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} state_t;

  state_t             st;
  logic               cs_q, sclk_q, valid_q, is_smp, gap_ph;
  logic [DIV_W-1:0]   ph_cnt, div_q;
  logic [CNT_W-1:0]   edge_cnt, edge_tgt, sd_tgt;
  logic [FRAME_LEN-1:0] sr, sr_nxt;
  logic [RES_W-1:0]   data_q;
  logic               tick, req;

  assign tick   = (ph_cnt == '0);
  assign req    = smp_req | pdn_req;
  assign sr_nxt = {sr[FRAME_LEN-2:0], adc_sdata};
  assign sd_tgt = (sd_edges == 4'd0)          ? CNT_W'(1) :
                  (int'(sd_edges) > SD_MAX)    ? CNT_W'(SD_MAX) :
                                                 CNT_W'(sd_edges);

  assign busy      = (st != S_IDLE);
  assign smp_valid = valid_q;
  assign smp_data  = data_q;
  assign adc_cs_n  = cs_q;
  assign adc_sclk  = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      valid_q  <= 1'b0;
      is_smp   <= 1'b0;
      gap_ph   <= 1'b0;
      ph_cnt   <= '0;
      div_q    <= '0;
      edge_cnt <= '0;
      edge_tgt <= '0;
      sr       <= '0;
      data_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            st       <= S_RUN;
            cs_q     <= 1'b0;
            ph_cnt   <= div_half;
            div_q    <= div_half;
            edge_cnt <= '0;
            is_smp   <= smp_req;
            edge_tgt <= smp_req ? CNT_W'(FRAME_LEN) : sd_tgt;
          end
        end
        S_RUN: begin
          if (tick) begin
            ph_cnt <= div_q;
            if (sclk_q) begin
              sclk_q   <= 1'b0;
              edge_cnt <= edge_cnt + 1'b1;
            end else begin
              sclk_q <= 1'b1;
              sr     <= sr_nxt;
              if (edge_cnt == edge_tgt) begin
                cs_q   <= 1'b1;
                st     <= S_GAP;
                gap_ph <= 1'b0;
                if (is_smp) begin
                  valid_q <= 1'b1;
                  data_q  <= sr_nxt[MSB_POS -: RES_W];
                end
              end
            end
          end else begin
            ph_cnt <= ph_cnt - 1'b1;
          end
        end
        S_GAP: begin
          if (tick) begin
            ph_cnt <= div_q;
            if (gap_ph) st <= S_IDLE;
            else        gap_ph <= 1'b1;
          end else begin
            ph_cnt <= ph_cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int FRAME_LEN = 16,
  parameter int SD_MAX    = 9
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic smp_valid,
  input logic adc_cs_n,
  input logic adc_sclk
);
  localparam int CNT_W = $clog2(FRAME_LEN + 2);

  logic             cs_d, sclk_d;
  logic [CNT_W-1:0] fc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b1;
      fc     <= '0;
    end else begin
      cs_d   <= adc_cs_n;
      sclk_d <= adc_sclk;
      if (cs_d && !adc_cs_n)                          fc <= '0;
      else if (!adc_cs_n && sclk_d && !adc_sclk)      fc <= fc + 1'b1;
    end
  end

  p_sclk_high_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);

  p_full_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (fc == CNT_W'(FRAME_LEN)));

  p_fall_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fc <= CNT_W'(FRAME_LEN));

  p_valid_at_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (adc_cs_n && !cs_d));

  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  p_short_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_cs_n && !cs_d && !smp_valid) |-> (fc >= CNT_W'(1) && fc <= CNT_W'(SD_MAX)));

  p_busy_covers_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy);
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
  .FRAME_LEN(FRAME_LEN),
  .SD_MAX(SD_MAX)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .busy(busy),
  .smp_valid(smp_valid),
  .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk)
);

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // {kind(1=sample), div[7:0], sd[3:0], code[9:0], expected falls[4:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 8'd0, 4'd0,  10'h3FF, 5'd16},
    {1'b1, 8'd1, 4'd0,  10'h000, 5'd16},
    {1'b1, 8'd3, 4'd0,  10'h2AA, 5'd16},
    {1'b0, 8'd0, 4'd1,  10'h000, 5'd1},
    {1'b0, 8'd2, 4'd9,  10'h000, 5'd9},
    {1'b0, 8'd1, 4'd0,  10'h000, 5'd1},
    {1'b0, 8'd0, 4'd12, 10'h000, 5'd9},
    {1'b1, 8'd2, 4'd0,  10'h155, 5'd16},
    {1'b0, 8'd0, 4'd5,  10'h000, 5'd5}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       smp_req = 1'b0, pdn_req = 1'b0;
  logic [7:0] div_half = '0;
  logic [3:0] sd_edges = '0;
  logic       busy, smp_valid, adc_cs_n, adc_sclk;
  logic       adc_sdata = 1'b0;
  logic [9:0] smp_data;

  int checks = 0, fails = 0;
  int falls = 0, vcnt = 0, idle_bad = 0;
  logic [15:0] word = '0;
  logic [9:0]  last_code = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_reader i_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .smp_req(smp_req), .pdn_req(pdn_req),
    .div_half(div_half), .sd_edges(sd_edges), .busy(busy),
    .smp_valid(smp_valid), .smp_data(smp_data), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_sdata(adc_sdata)
  );

  // converter model: one bit per falling serial clock edge
  always @(negedge adc_cs_n or negedge adc_sclk) begin
    if (adc_sclk) falls = 0;
    else if (!adc_cs_n) begin
      falls = falls + 1;
      if (falls <= 16) adc_sdata = word[16 - falls];
    end
  end

  always @(negedge clk) begin
    if (smp_valid) vcnt++;
    if (rst_n && adc_cs_n && !adc_sclk) idle_bad++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one frame; n counts falling clk edges after the request edge
  task automatic run_frame(input bit smp, input bit pdn, input int d, input int sd,
                           input logic [9:0] code, input int exp_falls,
                           input bit mid_poke);
    int n = 0, tval = 0, vbase;
    int nf = smp ? 16 : exp_falls;
    word = {3'b000, code, 3'b000};
    vbase = vcnt;
    div_half = 8'(d); sd_edges = 4'(sd);
    smp_req = smp; pdn_req = pdn;
    @(negedge clk);
    smp_req = 1'b0; pdn_req = 1'b0;
    n = 1;
    while (busy) begin
      if (smp_valid && tval == 0) tval = n;
      if (mid_poke && n == 5) begin
        smp_req = 1'b1; pdn_req = 1'b1;
        div_half = 8'd7; sd_edges = 4'd2;
      end
      if (mid_poke && n == 6) begin smp_req = 1'b0; pdn_req = 1'b0; end
      @(negedge clk);
      n++;
    end
    check("R2/R4 falling edges", falls, exp_falls);
    check("R3/R4 valid pulses", vcnt - vbase, smp ? 1 : 0);
    if (smp) begin
      check("R3 result code", int'(smp_data), int'(code));
      check("R5 valid latency", tval, 32*(d+1) + 1);
      last_code = code;
    end else begin
      check("R4 data held", int'(smp_data), int'(last_code));
    end
    check("R7 busy duration", n, 2*(nf+1)*(d+1) + 1);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cs_n", adc_cs_n, 1);
    check("R1 sclk", adc_sclk, 1);
    check("R1 busy", busy, 0);
    check("R1 valid", smp_valid, 0);
    check("R1 data", int'(smp_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cs_n after release", adc_cs_n, 1);
    check("R1 busy after release", busy, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v = VEC[i];
      run_frame(v[27], !v[27], int'(v[26:19]), int'(v[18:15]), v[14:5], int'(v[4:0]), 1'b0);
    end

    // R8, R10: requests and setting changes mid-frame are ignored
    run_frame(1'b1, 1'b0, 1, 0, 10'h1C3, 16, 1'b1);
    run_frame(1'b0, 1'b1, 0, 3, 10'h000, 3, 1'b1);
    // R9: both requests together run a sample frame
    run_frame(1'b1, 1'b1, 0, 4, 10'h0F0, 16, 1'b0);
    // R6: serial clock high whenever select is high
    check("R6 sclk idle high", idle_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule